// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block receives asynchronous serial characters on a single input line while running from a clock at sixteen times the bit rate. The line passes through a two-stage synchroniser. A low level seen while idle starts a character. Every bit is then sampled once, near the middle of its sixteen-clock cell. The start bit is checked again at its own midpoint, so a short glitch is dropped as a false start. The data bits come in least significant bit first. An optional parity bit follows them, and then the stop bit.

When the stop bit is sampled, the assembled character moves into a holding register and the data-ready flag is set. The parity result, the stop-bit check and an overrun indication are latched at the same moment. A host reads either the holding register or a status word through a chip-enable-qualified read port. Reading the holding register clears data-ready. Reading the status word clears the three error flags. Overrun and parity error are combined on one shared error output, but the status word keeps them as separate bits.

Top module: `uart_rx16`

## Requirements
- R1: After reset, data_avail, err_shared and frm_err are 0, and the status word reads 0.
- R2: Data bits are taken least significant bit first. At the stop-bit sample the holding register is loaded and data_avail rises.
- R3: cfg_len selects 5, 6, 7 or 8 data bits (codes 0 to 3). Holding-register bits above the selected length read 0.
- R4: A start bit that samples high at its midpoint is dropped. No word is loaded and the receiver returns to idle.
- R5: With par_en=1, the parity bit after the data is checked, even parity when par_odd=0 and odd when par_odd=1. A mismatch sets the parity flag when the word is loaded.
- R6: A stop bit that samples 0 sets frm_err when the word is loaded.
- R7: A read is qualified only when chip_en_a=1, chip_en_b=1, chip_en_n=0 and rnw=1. A qualified read with reg_sel=0 returns the holding register and clears data_avail. An unqualified read changes nothing.
- R8: Loading a word while data_avail is still set, with no clearing read in the same cycle, sets the overrun flag.
- R9: err_shared is the OR of the overrun and parity flags. The status word (reg_sel=1) holds data_avail in bit 0, overrun in bit 1, parity error in bit 2, framing error in bit 3, and zeros above.
- R10: A qualified status read clears the overrun, parity and framing flags. Loading a new word replaces all three with that word's results, so an error-free word clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, 16x bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial data in, idle high |
| cfg_len | input | 2 | Data length code: 5 plus this value |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| chip_en_a | input | 1 | Read qualifier, active high |
| chip_en_b | input | 1 | Read qualifier, active high |
| chip_en_n | input | 1 | Read qualifier, active low |
| rnw | input | 1 | 1 marks a read access |
| reg_sel | input | 1 | 0 selects the holding register, 1 selects status |
| rd_data | output | 8 | Holding register or status word |
| data_avail | output | 1 | Unread word present |
| err_shared | output | 1 | Overrun OR parity error |
| frm_err | output | 1 | Framing error flag |

## Verification
The hardest condition to reach from the ports is an overrun. A complete second frame has to arrive while data_avail from the first is still set, and a wrong read qualifier must not clear it in between. The stimulus sends two frames back to back without reading, tries a read with chip_en_n high in between, and then confirms that the two error sources stay separate in the status word while err_shared shows their OR. False starts and a bad stop bit are built by shaping rxd directly: a low pulse shorter than half a cell, and a frame whose stop cell is held low.

// File: rtl/uart_rx16.sv
module uart_rx16 #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [1:0]        cfg_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              chip_en_a,
  input  logic              chip_en_b,
  input  logic              chip_en_n,
  input  logic              rnw,
  input  logic              reg_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_avail,
  output logic              err_shared,
  output logic              frm_err
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t              st;
  logic [1:0]       sync;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic [DATA_W-1:0] shreg, hold;
  logic             par_acc, ovr_q, par_q;

  wire rx      = sync[1];
  wire mid     = (cnt == MID);
  wire last    = (cnt == LAST);
  wire rd_q    = chip_en_a & chip_en_b & ~chip_en_n & rnw;
  wire data_rd = rd_q & ~reg_sel;
  wire stat_rd = rd_q & reg_sel;
  wire load    = (st == S_STOP) & mid;
  wire perr    = par_en & (par_acc ^ par_odd);
  wire [IW-1:0] last_idx = IW'(DATA_W - 4) + IW'(cfg_len);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
    end else begin
      cnt <= last ? '0 : cnt + CW'(1);
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!rx) st <= S_START;
        end
        S_START: begin
          if (mid && rx) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else if (last) begin
            st      <= S_DATA;
            idx     <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
          end
        end
        S_DATA: begin
          if (mid) begin
            for (int i = 0; i < DATA_W; i++)
              if (idx == IW'(i)) shreg[i] <= rx;
            par_acc <= par_acc ^ rx;
          end
          if (last) begin
            idx <= idx + IW'(1);
            if (idx == last_idx) st <= par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          if (mid)  par_acc <= par_acc ^ rx;
          if (last) st <= S_STOP;
        end
        S_STOP: begin
          if (mid) begin
            st  <= S_IDLE;
            cnt <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold       <= '0;
      data_avail <= 1'b0;
      ovr_q      <= 1'b0;
      par_q      <= 1'b0;
      frm_err    <= 1'b0;
    end else if (load) begin
      hold       <= shreg;
      data_avail <= 1'b1;
      ovr_q      <= data_avail & ~data_rd;
      par_q      <= perr;
      frm_err    <= ~rx;
    end else begin
      if (data_rd) data_avail <= 1'b0;
      if (stat_rd) begin
        ovr_q   <= 1'b0;
        par_q   <= 1'b0;
        frm_err <= 1'b0;
      end
    end
  end

  wire [DATA_W-1:0] status = {{(DATA_W-4){1'b0}}, frm_err, par_q, ovr_q, data_avail};

  assign rd_data    = reg_sel ? status : hold;
  assign err_shared = ovr_q | par_q;
endmodule

// File: rtl/uart_rx16_chk.sv
module uart_rx16_chk (
  input logic clk,
  input logic rst_n,
  input logic data_rd,
  input logic stat_rd,
  input logic load,
  input logic data_avail,
  input logic err_shared,
  input logic frm_err,
  input logic ovr_q
);
  assert_avail_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_avail) |-> $past(load));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !load) |=> !data_avail);

  assert_ovr_needs_avail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(data_avail));

  assert_frm_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_err) |-> $past(load));

  assert_status_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !load) |=> (!frm_err && !err_shared));

  assert_flags_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !stat_rd) |=> $stable(ovr_q) && $stable(frm_err));
endmodule

bind uart_rx16 uart_rx16_chk i_chk (
  .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .stat_rd(stat_rd), .load(load),
  .data_avail(data_avail), .err_shared(err_shared), .frm_err(frm_err), .ovr_q(ovr_q)
);

// File: tb/test_uart_rx16.sv
module test_uart_rx16;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic par_en = 1'b0, par_odd = 1'b0;
  logic chip_en_a = 1'b0, chip_en_b = 1'b0, chip_en_n = 1'b1, rnw = 1'b0, reg_sel = 1'b0;
  logic [7:0] rd_data;
  logic data_avail, err_shared, frm_err;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  uart_rx16 i_uart_rx16 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .cfg_len(cfg_len), .par_en(par_en),
    .par_odd(par_odd), .chip_en_a(chip_en_a), .chip_en_b(chip_en_b),
    .chip_en_n(chip_en_n), .rnw(rnw), .reg_sel(reg_sel), .rd_data(rd_data),
    .data_avail(data_avail), .err_shared(err_shared), .frm_err(frm_err)
  );

  // fields: len[23:22] pen[21] podd[20] badpar[19] badstop[18] data[17:10] exp[9:2] exp_pe[1] exp_fe[0]
  localparam logic [23:0] VEC [0:6] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFB, 8'h1B, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3D, 8'h3D, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 8'h55, 8'h55, 1'b1, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 8'h81, 1'b0, 1'b1},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h3F, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cells(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pen, input bit podd,
                      input bit badp, input bit bads);
    logic p;
    p = podd ^ badp;
    cells(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      cells(d[i], 16);
      p ^= d[i];
    end
    if (pen) cells(p, 16);
    cells(~bads, 16);
    cells(1'b1, 24);
  endtask

  task automatic rd(input bit sel, input bit qual, output logic [7:0] v);
    @(negedge clk);
    chip_en_a = 1'b1; chip_en_b = 1'b1; rnw = 1'b1; reg_sel = sel;
    chip_en_n = ~qual;
    #1 v = rd_data;
    @(negedge clk);
    chip_en_a = 1'b0; chip_en_b = 1'b0; rnw = 1'b0; chip_en_n = 1'b1; reg_sel = 1'b0;
    #1;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [23:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!data_avail && !err_shared && !frm_err, "R1 reset flags", {data_avail, err_shared, frm_err}, 0);
    rd(1'b1, 1'b1, v);
    chk(v == 8'h00, "R1 reset status", v, 0);
    cells(1'b1, 8);

    for (int k = 0; k < 7; k++) begin
      e = VEC[k];
      cfg_len = e[23:22]; par_en = e[21]; par_odd = e[20];
      send(e[17:10], 5 + int'(e[23:22]), e[21], e[20], e[19], e[18]);
      chk(data_avail, "R2 avail after frame", data_avail, 1);
      rd(1'b1, 1'b1, v);
      chk(v == {4'h0, e[0], e[1], 1'b0, 1'b1}, "R5 R6 R9 status bits", v, {4'h0, e[0], e[1], 1'b0, 1'b1});
      rd(1'b0, 1'b1, v);
      chk(v == e[9:2], "R2 R3 data", v, e[9:2]);
      chk(!data_avail, "R7 read clears avail", data_avail, 0);
      chk(!err_shared && !frm_err, "R10 status read clears", {err_shared, frm_err}, 0);
    end

    cfg_len = 2'd3; par_en = 1'b0; par_odd = 1'b0;
    cells(1'b0, 5);
    cells(1'b1, 40);
    chk(!data_avail, "R4 false start ignored", data_avail, 0);
    send(8'h6E, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(1'b0, 1'b1, v);
    chk(v == 8'h6E, "R4 next frame after false start", v, 8'h6E);

    send(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(1'b0, 1'b0, v);
    chk(data_avail, "R7 unqualified read ignored", data_avail, 1);
    send(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(err_shared, "R8 R9 overrun on shared out", err_shared, 1);
    rd(1'b1, 1'b1, v);
    chk(v == 8'h03, "R8 R9 overrun status", v, 8'h03);
    chk(!err_shared && data_avail, "R10 status read keeps avail", {err_shared, data_avail}, 2'b01);
    rd(1'b0, 1'b1, v);
    chk(v == 8'h22, "R8 newest word held", v, 8'h22);

    par_en = 1'b1;
    send(8'h0F, 8, 1'b1, 1'b0, 1'b1, 1'b0);
    chk(err_shared, "R5 R9 parity on shared out", err_shared, 1);
    rd(1'b0, 1'b1, v);
    send(8'h0F, 8, 1'b1, 1'b0, 1'b0, 1'b0);
    rd(1'b1, 1'b1, v);
    chk(v == 8'h01, "R10 clean word clears errors", v, 8'h01);

    finish_run();
  end
endmodule